// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block holds the interrupt cause register of a network controller together with its enable mask. Hardware event lines set individual cause bits. Software uses a small synchronous register port to acknowledge causes by writing ones, to inject causes, and to set or clear mask bits. The pending set is the cause register ANDed with the mask. One level-sensitive interrupt line is driven from the pending set.

Bit 24 of the cause register is a summary "other" cause. It is raised whenever any of the secondary causes 2, 6, 9, 16, 17 or 18 is set. Bit 6 is the receive-overrun cause. Software can leave a secondary cause masked and watch only the summary bit. To stop the interrupt from firing again and again, acknowledging the summary bit also clears every secondary cause.

An optional auto-mask feature is also provided. When it is enabled and the interrupt is asserted, any write to the cause register first clears the mask bits selected by an auto-mask register.

Top module: `intr_cause_ctrl`

Register map (word address on `addr`):

| Address | Register | Write effect | Read value |
|---|---|---|---|
| 0 | cause | write-one-to-clear | cause register, with bit 31 set to the asserted flag |
| 1 | cause-set | OR the written value into the cause register | 0 |
| 2 | mask-set | OR the written value into the mask | mask |
| 3 | mask-clear | clear the mask bits written as one | mask |
| 4 | auto-mask | replace the auto-mask selection | auto-mask selection |
| 5 | extended control | bit 0 is the auto-mask enable | `{31'b0, enable}` |

Any other address reads 0.

## Requirements
- R1: After reset, the cause, mask and auto-mask registers are zero, the enable is zero, every address reads 0 and `irqOut` is low.
- R2: A one on `evtIn[k]` sets cause bit k for every k from 0 to 30 (bit 6 is receive overrun). `evtIn[31]` has no effect.
- R3: In any cycle where cause bit 2, 6, 9, 16, 17 or 18 is set by an event or by a cause-set write, cause bit 24 is also set.
- R4: A write to address 0 clears each cause bit that is written as one and leaves every bit written as zero unchanged.
- R5: A write to address 0 with bit 24 set also clears cause bits 2, 6, 9, 16, 17 and 18, even where those bits are written as zero.
- R6: When an event and a software clear hit the same cause bit in the same cycle, the bit stays set. If that bit is a secondary cause, bit 24 is set as well.
- R7: A write to address 1 ORs the written value into cause bits 30..0. Bit 24 follows the R3 rule.
- R8: A write to address 2 ORs the written value into the mask. A write to address 3 clears the mask bits written as one. Both addresses read back the mask.
- R9: The pending set is cause AND mask. `irqOut` and the read-back bit 31 of address 0 are high exactly when the pending set is nonzero. A masked bit 6 signals only through an unmasked bit 24.
- R10: A write to address 0 that happens while `irqOut` is high and the enable bit (address 5, bit 0) is set first clears the mask bits selected by the auto-mask register (address 4). If either condition is false, the mask is left unchanged.
- R11: `irqOut` changes in the clock cycle after the write or event that changes the pending set, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| evtIn | input | 32 | Hardware cause events, one per cause bit |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Read-back of the register at `addr` |
| irqOut | output | 1 | Interrupt line, high while anything is pending |

## Verification
The register port can issue at most one write per cycle, so no mask-set or mask-clear write can land in the same cycle as the cause write that fires auto-mask. The write-one-to-clear and summary-clear properties take it that `evtIn` is idle in the cycle of the write. The bench keeps the event lines quiet around every write except in the scenario that deliberately collides an event with a clear, and that scenario is checked only through the event-wins property. All stimulus changes on the falling edge, one register access at a time.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
  localparam int CAUSE_ADDR  = 0;
  localparam int CSET_ADDR   = 1;
  localparam int MSET_ADDR   = 2;
  localparam int MCLR_ADDR   = 3;
  localparam int AUTOM_ADDR  = 4;
  localparam int EXTC_ADDR   = 5;

  typedef struct packed {
    logic causeClr;
    logic causeSet;
    logic maskSet;
    logic maskClr;
    logic autoMaskWr;
    logic extWr;
    logic autoFire;
  } strobe_t;
endpackage

// File: rtl/intr_cause_ctl.sv
module intr_cause_ctl
  import intr_cause_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              asserted,
  input  logic              autoMaskEn,
  output strobe_t           strb
);
  always_comb begin
    strb            = '0;
    strb.causeClr   = wrEn && (addr == ADDR_W'(CAUSE_ADDR));
    strb.causeSet   = wrEn && (addr == ADDR_W'(CSET_ADDR));
    strb.maskSet    = wrEn && (addr == ADDR_W'(MSET_ADDR));
    strb.maskClr    = wrEn && (addr == ADDR_W'(MCLR_ADDR));
    strb.autoMaskWr = wrEn && (addr == ADDR_W'(AUTOM_ADDR));
    strb.extWr      = wrEn && (addr == ADDR_W'(EXTC_ADDR));
    // auto-mask fires only on a cause write that sees the interrupt asserted
    strb.autoFire   = strb.causeClr && asserted && autoMaskEn;
  end
endmodule

// File: rtl/intr_cause_dp.sv
module intr_cause_dp
  import intr_cause_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 3,
  parameter int              OTHER_POS  = 24,
  parameter int              ASSERT_POS = 31,
  parameter int              EN_POS     = 0,
  parameter logic [DATA_W-1:0] SEC_MASK = 32'h0007_0244
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] evtIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] causeQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] autoMaskQ,
  output logic              autoMaskEn,
  output logic              asserted
);
  localparam logic [DATA_W-1:0] OTHER_BIT  = DATA_W'(1) << OTHER_POS;
  localparam logic [DATA_W-1:0] ASSERT_BIT = DATA_W'(1) << ASSERT_POS;

  logic [DATA_W-1:0] rawSet, setVec, clrVec, causeD, maskD, pending;

  always_comb begin
    rawSet = (evtIn | (strb.causeSet ? wrData : '0)) & ~ASSERT_BIT;
    setVec = ((rawSet & SEC_MASK) != '0) ? (rawSet | OTHER_BIT) : rawSet;
    clrVec = '0;
    if (strb.causeClr) begin
      clrVec = wrData;
      if (wrData[OTHER_POS]) clrVec = clrVec | SEC_MASK;
    end
    // sets are applied after clears so an event wins over a clear
    causeD = ((causeQ & ~clrVec) | setVec) & ~ASSERT_BIT;
  end

  always_comb begin
    maskD = maskQ;
    if (strb.autoFire) maskD = maskD & ~autoMaskQ;
    if (strb.maskSet)  maskD = maskD | wrData;
    if (strb.maskClr)  maskD = maskD & ~wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ     <= '0;
      maskQ      <= '0;
      autoMaskQ  <= '0;
      autoMaskEn <= 1'b0;
    end else begin
      causeQ <= causeD;
      maskQ  <= maskD;
      if (strb.autoMaskWr) autoMaskQ  <= wrData;
      if (strb.extWr)      autoMaskEn <= wrData[EN_POS];
    end
  end

  assign pending  = causeQ & maskQ;
  assign asserted = |pending;

  always_comb begin
    case (int'(addr))
      CAUSE_ADDR:            rdData = (causeQ & ~ASSERT_BIT) | (asserted ? ASSERT_BIT : '0);
      MSET_ADDR, MCLR_ADDR:  rdData = maskQ;
      AUTOM_ADDR:            rdData = autoMaskQ;
      EXTC_ADDR:             rdData = DATA_W'(autoMaskEn) << EN_POS;
      default:               rdData = '0;
    endcase
  end
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_cause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] evtIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  strobe_t           strb;
  logic [DATA_W-1:0] causeQ, maskQ, autoMaskQ;
  logic              autoMaskEn, asserted;

  intr_cause_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .wrEn(wrEn), .addr(addr), .asserted(asserted),
    .autoMaskEn(autoMaskEn), .strb(strb)
  );

  intr_cause_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .causeQ(causeQ), .maskQ(maskQ),
    .autoMaskQ(autoMaskQ), .autoMaskEn(autoMaskEn), .asserted(asserted)
  );

  assign irqOut = asserted;
endmodule

// File: rtl/intr_cause_chk.sv
module intr_cause_chk #(
  parameter int              DATA_W    = 32,
  parameter int              ADDR_W    = 3,
  parameter int              OTHER_POS = 24,
  parameter logic [DATA_W-1:0] SEC_MASK = 32'h0007_0244
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] evtIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic [DATA_W-1:0] causeQ,
  input logic [DATA_W-1:0] maskQ,
  input logic [DATA_W-1:0] autoMaskQ,
  input logic              autoMaskEn
);
  localparam logic [DATA_W-1:0] LOW_BITS = {1'b0, {(DATA_W-1){1'b1}}};

  p_other_follows_secondary_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & SEC_MASK) != '0) |-> causeQ[OTHER_POS]);

  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0) && evtIn == '0) |=> ((causeQ & $past(wrData) & LOW_BITS) == '0));

  p_other_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0) && wrData[OTHER_POS] && evtIn == '0)
      |=> ((causeQ & SEC_MASK) == '0 && !causeQ[OTHER_POS]));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((evtIn & LOW_BITS) != '0) |=> ((causeQ & $past(evtIn) & LOW_BITS) == ($past(evtIn) & LOW_BITS)));

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(2)) |=> ((maskQ & $past(wrData)) == $past(wrData)));

  p_quiet_when_none_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & maskQ) == '0) |-> !irqOut);

  p_automask_fire_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0) && irqOut && autoMaskEn) |=> ((maskQ & $past(autoMaskQ)) == '0));
endmodule

bind intr_cause_ctrl intr_cause_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .irqOut(irqOut), .causeQ(causeQ), .maskQ(maskQ),
  .autoMaskQ(autoMaskQ), .autoMaskEn(autoMaskEn)
);

// File: tb/intr_cause_ctrl_bench.sv
module intr_cause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  intr_cause_ctrl u_intr_cause_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic wrEvt(input logic [2:0] a, input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; evtIn = e;
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEvt(a, d, '0);
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic clearAll();
    wr(3'd5, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 reset irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(32'h0000_0040);
    rd(3'd0, v);
    check("R2 R3 overrun sets 6 and 24", v, 32'h0100_0040);
    check("R9 masked stays quiet", {31'b0, irqOut}, 32'h0);
    pulse(32'h8000_0000);
    rd(3'd0, v);
    check("R2 event 31 ignored", v, 32'h0100_0040);
    // unmask only the summary bit; irq must wait for the edge
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd2; wrData = 32'h0100_0000;
    #1 check("R11 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    wrEn = 1'b0;
    check("R11 R9 irq via summary", {31'b0, irqOut}, 32'h1);
    rd(3'd0, v);
    check("R9 asserted flag", v, 32'h8100_0040);
    rd(3'd2, v);
    check("R8 mask read", v, 32'h0100_0000);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0040);
    rd(3'd0, v);
    check("R4 w1c only bit 6", v, 32'h8100_0000);
    pulse(32'h0003_0244);
    wr(3'd0, 32'h0100_0000);
    rd(3'd0, v);
    check("R5 summary clear takes secondaries", v, 32'h0);
    check("R5 irq drops", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(3'd1, 32'h8000_0001);
    rd(3'd0, v);
    check("R7 cause-set plain bit", v, 32'h0000_0001);
    wr(3'd1, 32'h0002_0000);
    rd(3'd0, v);
    check("R7 R3 cause-set secondary", v, 32'h8102_0001);
    rd(3'd1, v);
    check("R7 set addr reads 0", v, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(32'h0000_0040);
    wrEvt(3'd0, 32'h0000_0040, 32'h0000_0040);
    rd(3'd0, v);
    check("R6 event beats bit clear", v, 32'h8100_0040);
    wrEvt(3'd0, 32'h0100_0000, 32'h0000_0040);
    rd(3'd0, v);
    check("R6 event beats summary clear", v, 32'h8100_0040);
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd2, 32'h0000_000F);
    wr(3'd3, 32'h0100_0005);
    rd(3'd3, v);
    check("R8 mask clear", v, 32'h0000_000A);
  endtask

  task automatic t_automask();
    logic [31:0] v;
    wr(3'd4, 32'h0000_0008);
    wr(3'd5, 32'h0000_0001);
    rd(3'd5, v);
    check("R10 enable reads back", v, 32'h1);
    wr(3'd1, 32'h0000_0008);
    check("R10 asserted before", {31'b0, irqOut}, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd2, v);
    check("R10 auto-mask fired", v, 32'h0000_0002);
    rd(3'd0, v);
    check("R10 cause kept", v, 32'h0000_0008);
    // disabled: no effect
    wr(3'd5, 32'h0);
    wr(3'd2, 32'h0000_0008);
    wr(3'd0, 32'h0);
    rd(3'd2, v);
    check("R10 disabled no auto-mask", v, 32'h0000_000A);
    // enabled but not asserted: no effect
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd2, v);
    check("R10 not asserted no auto-mask", v, 32'h0000_000A);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_events();
    t_clear();
    t_set();
    t_collide();
    t_mask();
    t_automask();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule